// File: doc/BRIEF.md
# Prefix Relocation and Low-Address Guard

This unit converts a real address into an absolute address. The lowest 8 KB of the address space and an 8 KB area chosen by a prefix register trade places. A real address in the bottom 8 KB goes to the matching byte of the prefix area. A real address inside the prefix area goes to the matching byte of page zero. Every other address is unchanged. The prefix register sits inside the block. It is written through a dedicated strobe and always holds an 8 KB-aligned value.

The same request also goes through a low-address store guard. The guarded bytes are two 512-byte windows: one at the start of page 0 and one at the start of page 1. The guard's state depends on three things: a protection-enable control bit, whether address translation is on, and, when translation is on, the private bit of the selected address space. A store to a guarded byte is refused. For any access to page 0 or page 1 while the guard is active, the response flags the cached translation as unfit for reuse by later writes. The access-register space mode is refused with an error output.

Requests use a valid/ready handshake. Each accepted request produces exactly one registered response in the next cycle.

Top module: `lowcore_remap_unit`

## Requirements
- R1: A request address below 0x2000 produces an absolute address equal to the address plus the prefix value.
- R2: A request address from the prefix up to prefix+0x1FFF (both ends included) produces the address minus the prefix, which lands in page zero. This holds only when the address is not below 0x2000.
- R3: Every other address passes through unchanged. With a prefix of zero, all addresses are unchanged.
- R4: The prefix resets to zero. A prefix write keeps only bits 63:13 of the written value and clears bits 12:0.
- R5: A store (access code 01) to a guarded byte, while the guard is active, raises the protection fault and returns an absolute address of zero. The guarded bytes are 0x000 to 0x1FF and 0x1000 to 0x11FF. A store to any other byte gets a normal translation and no fault.
- R6: When the protection-enable bit is clear, the guard is inactive: no fault and no reuse flag.
- R7: When the protection-enable bit is set and translation is off, the guard is active whatever the space mode and private bits are.
- R8: When translation is on, the guard is active only if the selected space's private bit is clear. The private bits are mapped as follows:

  | Space code | Space | Private bit |
  |---|---|---|
  | 00 | primary | bit 0 |
  | 10 | secondary | bit 1 |
  | 11 | home | bit 2 |
- R9: While the guard is active, any access whose address is below 0x2000 raises the write-reuse flag. This covers loads (code 00), fetches (code 10), stores that fault, and bytes outside the guarded windows.
- R10: When translation is on and the space mode is 01, the response raises the mode error. It then raises no fault and no reuse flag, and returns an absolute address of zero.
- R11: A request is accepted when req_valid and req_ready are both high. The response comes with rsp_valid one cycle after acceptance. req_ready is low in any cycle in which the prefix is being written, and a request offered in that cycle produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prefix_wr | input | 1 | Prefix register write strobe |
| prefix_wdata | input | ADDR_W | New prefix value; bits 12:0 are ignored |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Real address |
| req_acc | input | 2 | Access type: 00 load, 01 store, 10 fetch |
| prot_en | input | 1 | Low-address protection enable |
| xlate_on | input | 1 | Address translation enabled |
| space_sel | input | 2 | Space mode: 00 primary, 01 access-register, 10 secondary, 11 home |
| space_private | input | 3 | Private bits for primary, secondary and home |
| rsp_valid | output | 1 | Response present |
| rsp_abs_addr | output | ADDR_W | Absolute address (zero on fault or error) |
| rsp_prot_fault | output | 1 | Store to a guarded byte was refused |
| rsp_wr_noreuse | output | 1 | Translation must not be reused for writes |
| rsp_mode_err | output | 1 | Unsupported space mode |

## Verification
The address swap is tested with a zero prefix and then with a nonzero prefix whose written value has junk in bits 12:0. Sample addresses sit at both edges of the low window, both edges of the prefix window, and just outside each. This separates a wrong window bound from a missed alignment mask. The guard is tested by varying several inputs independently:

- stores and loads at the first and last bytes of each guarded window, and just past them;
- the protection-enable bit;
- the translation flag;
- each space mode with its own private bit set or clear, and with the other private bits set the opposite way.

A wrong private-bit mapping or a guard that ignores translation shows up in these results. The handshake is tested by offering a request during a prefix write and checking that no response appears.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_SPARE = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        SPC_PRIMARY   = 2'b00,
        SPC_ACCREG    = 2'b01,
        SPC_SECONDARY = 2'b10,
        SPC_HOME      = 2'b11
    } space_e;

    localparam int PAGE_BITS  = 12;
    localparam int WIN_BITS   = 13;
    localparam int GUARD_SPAN = 512;
    localparam int N_SPACES   = 3;

endpackage

// File: rtl/lcr_prefix_reg.sv
module lcr_prefix_reg #(
    parameter int ADDR_W   = 64,
    parameter int WIN_BITS = 13,
    localparam int HI_W    = ADDR_W - WIN_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [HI_W-1:0] wr_hi,
    output logic [HI_W-1:0] prefix_hi
);

    logic [HI_W-1:0] prefix_d, prefix_q;

    always_comb begin
        prefix_d = prefix_q;
        if (wr_en) begin
            prefix_d = wr_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prefix_q <= '0;
        end else begin
            prefix_q <= prefix_d;
        end
    end

    assign prefix_hi = prefix_q;

    // R4
    prefix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(prefix_hi));

endmodule

// File: rtl/lcr_addr_swap.sv
module lcr_addr_swap #(
    parameter int ADDR_W   = 64,
    parameter int WIN_BITS = 13,
    localparam int HI_W    = ADDR_W - WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] real_i,
    input  logic [HI_W-1:0]   prefix_hi,
    output logic [ADDR_W-1:0] abs_o
);

    logic [HI_W-1:0]     page_hi;
    logic [WIN_BITS-1:0] offs;
    logic                in_low, in_pfx;

    always_comb begin
        page_hi = real_i[ADDR_W-1:WIN_BITS];
        offs    = real_i[WIN_BITS-1:0];
        in_low  = (page_hi == '0);
        in_pfx  = (page_hi == prefix_hi);
        if (in_low) begin
            abs_o = {prefix_hi, offs};
        end else if (in_pfx) begin
            abs_o = {{HI_W{1'b0}}, offs};
        end else begin
            abs_o = real_i;
        end
    end

    // R1 R2 R3: the offset inside an 8 KB window never changes
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abs_o[WIN_BITS-1:0] == real_i[WIN_BITS-1:0]);

endmodule

// File: rtl/lcr_guard.sv
module lcr_guard
    import lcr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   real_i,
    input  logic                is_store,
    input  logic                prot_en,
    input  logic                xlate_on,
    input  space_e              space,
    input  logic [N_SPACES-1:0] private_i,
    output logic                fault_o,
    output logic                noreuse_o,
    output logic                mode_err_o
);

    localparam logic [ADDR_W-1:0] LOW_LIMIT  = ADDR_W'(2 ** (PAGE_BITS + 1));
    localparam logic [ADDR_W-1:0] PG1_BASE   = ADDR_W'(2 ** PAGE_BITS);
    localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(GUARD_SPAN);

    logic low_page, low_byte, priv_sel, guard_on;

    always_comb begin
        low_page = (real_i < LOW_LIMIT);
        low_byte = (real_i < SPAN) ||
                   ((real_i >= PG1_BASE) && (real_i < PG1_BASE + SPAN));
        unique case (space)
            SPC_SECONDARY: priv_sel = private_i[1];
            SPC_HOME:      priv_sel = private_i[2];
            default:       priv_sel = private_i[0];
        endcase
        mode_err_o = xlate_on && (space == SPC_ACCREG);
        guard_on   = prot_en && !mode_err_o && (!xlate_on || !priv_sel);
        noreuse_o  = guard_on && low_page;
        fault_o    = noreuse_o && low_byte && is_store;
    end

    // R9
    fault_implies_noreuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> noreuse_o);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> (!fault_o && !noreuse_o));

    // R6
    guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> !noreuse_o);

endmodule

// File: rtl/lowcore_remap_unit.sv
module lowcore_remap_unit
    import lcr_pkg::*;
#(
    parameter int ADDR_W = 64,
    localparam int HI_W  = ADDR_W - WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prefix_wr,
    input  logic [ADDR_W-1:0] prefix_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_acc,
    input  logic              prot_en,
    input  logic              xlate_on,
    input  logic [1:0]        space_sel,
    input  logic [2:0]        space_private,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_abs_addr,
    output logic              rsp_prot_fault,
    output logic              rsp_wr_noreuse,
    output logic              rsp_mode_err
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              fault;
        logic              noreuse;
        logic              err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [HI_W-1:0]   prefix_hi;
    logic [ADDR_W-1:0] swapped;
    logic              g_fault, g_noreuse, g_err, accept;
    logic              unused_prefix_low;

    assign unused_prefix_low = ^prefix_wdata[WIN_BITS-1:0];

    lcr_prefix_reg #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) i_prefix (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prefix_wr),
        .wr_hi     (prefix_wdata[ADDR_W-1:WIN_BITS]),
        .prefix_hi (prefix_hi)
    );

    lcr_addr_swap #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) i_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .real_i    (req_addr),
        .prefix_hi (prefix_hi),
        .abs_o     (swapped)
    );

    lcr_guard #(.ADDR_W(ADDR_W)) i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .real_i     (req_addr),
        .is_store   (req_acc == ACC_STORE),
        .prot_en    (prot_en),
        .xlate_on   (xlate_on),
        .space      (space_e'(space_sel)),
        .private_i  (space_private),
        .fault_o    (g_fault),
        .noreuse_o  (g_noreuse),
        .mode_err_o (g_err)
    );

    assign req_ready = !prefix_wr;
    assign accept    = req_valid && req_ready;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = accept;
        if (accept) begin
            rsp_d.fault   = g_fault;
            rsp_d.noreuse = g_noreuse;
            rsp_d.err     = g_err;
            rsp_d.addr    = (g_fault || g_err) ? '0 : swapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_abs_addr   = rsp_q.addr;
    assign rsp_prot_fault = rsp_q.fault;
    assign rsp_wr_noreuse = rsp_q.noreuse;
    assign rsp_mode_err   = rsp_q.err;

    // R5
    fault_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_fault |-> ($past(req_acc) == ACC_STORE));

    // R5
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot_fault |-> (rsp_abs_addr == '0));

    // R11
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid) && !$past(prefix_wr)));

    // R10
    err_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mode_err |-> (rsp_abs_addr == '0 && rsp_valid));

endmodule

// File: tb/test_lowcore_remap_unit.sv
module test_lowcore_remap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prefix_wr = 1'b0;
    logic [63:0] prefix_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_acc = 2'b00;
    logic        prot_en = 1'b0;
    logic        xlate_on = 1'b0;
    logic [1:0]  space_sel = 2'b00;
    logic [2:0]  space_private = 3'b000;
    logic        rsp_valid;
    logic [63:0] rsp_abs_addr;
    logic        rsp_prot_fault, rsp_wr_noreuse, rsp_mode_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lowcore_remap_unit i_lowcore_remap_unit (
        .clk(clk), .rst_n(rst_n), .prefix_wr(prefix_wr), .prefix_wdata(prefix_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_acc(req_acc), .prot_en(prot_en), .xlate_on(xlate_on),
        .space_sel(space_sel), .space_private(space_private),
        .rsp_valid(rsp_valid), .rsp_abs_addr(rsp_abs_addr),
        .rsp_prot_fault(rsp_prot_fault), .rsp_wr_noreuse(rsp_wr_noreuse),
        .rsp_mode_err(rsp_mode_err)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one request, response sampled at the following falling edge
    task automatic send(logic [63:0] a, logic [1:0] acc);
        req_addr  = a;
        req_acc   = acc;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(string tag, logic [63:0] addr, logic f, logic nr, logic e);
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " addr"}, rsp_abs_addr, addr);
        check({tag, " fault"}, 64'(rsp_prot_fault), 64'(f));
        check({tag, " noreuse"}, 64'(rsp_wr_noreuse), 64'(nr));
        check({tag, " err"}, 64'(rsp_mode_err), 64'(e));
    endtask

    task automatic t_reset;
        check("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 reset req_ready", 64'(req_ready), 64'd1);
        send(64'h100, 2'b00);
        expect_rsp("R4 reset prefix zero", 64'h100, 0, 0, 0);
        send(64'h34010, 2'b00);
        expect_rsp("R3 zero prefix identity", 64'h34010, 0, 0, 0);
    endtask

    task automatic t_prefix_write;
        prefix_wr    = 1'b1;
        prefix_wdata = 64'h35FFF;
        req_addr     = 64'h10;
        req_valid    = 1'b1;
        #1;
        check("R11 ready low during prefix write", 64'(req_ready), 64'd0);
        @(negedge clk);
        prefix_wr = 1'b0;
        req_valid = 1'b0;
        check("R11 stalled request gives no response", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check("R11 response drops after one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_swap;
        send(64'h1ABC, 2'b00);  expect_rsp("R1 R4 low window", 64'h35ABC, 0, 0, 0);
        send(64'h0, 2'b10);     expect_rsp("R1 low edge", 64'h34000, 0, 0, 0);
        send(64'h34010, 2'b00); expect_rsp("R2 prefix window", 64'h10, 0, 0, 0);
        send(64'h35FFF, 2'b00); expect_rsp("R2 top of prefix window", 64'h1FFF, 0, 0, 0);
        send(64'h36000, 2'b00); expect_rsp("R3 above prefix", 64'h36000, 0, 0, 0);
        send(64'h33FFF, 2'b00); expect_rsp("R3 below prefix", 64'h33FFF, 0, 0, 0);
        send(64'h2000, 2'b01);  expect_rsp("R3 first byte past low", 64'h2000, 0, 0, 0);
        @(negedge clk);
        check("R11 single response", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_guard_real;
        prot_en = 1'b1; xlate_on = 1'b0; space_sel = 2'b01; space_private = 3'b111;
        send(64'h1FF, 2'b01);  expect_rsp("R5 R7 store end of window 0", 64'h0, 1, 1, 0);
        send(64'h200, 2'b01);  expect_rsp("R5 R9 store past window 0", 64'h34200, 0, 1, 0);
        send(64'h1000, 2'b01); expect_rsp("R5 store start of window 1", 64'h0, 1, 1, 0);
        send(64'h11FF, 2'b01); expect_rsp("R5 store end of window 1", 64'h0, 1, 1, 0);
        send(64'h1200, 2'b01); expect_rsp("R5 store past window 1", 64'h35200, 0, 1, 0);
        send(64'h0, 2'b00);    expect_rsp("R9 load guarded byte", 64'h34000, 0, 1, 0);
        send(64'h10, 2'b10);   expect_rsp("R9 fetch guarded byte", 64'h34010, 0, 1, 0);
        send(64'h1FFF, 2'b01); expect_rsp("R9 last low byte", 64'h35FFF, 0, 1, 0);
        prot_en = 1'b0;
        send(64'h10, 2'b01);   expect_rsp("R6 guard disabled", 64'h34010, 0, 0, 0);
    endtask

    task automatic t_guard_spaces;
        prot_en = 1'b1; xlate_on = 1'b1;
        space_sel = 2'b00; space_private = 3'b001;
        send(64'h10, 2'b01); expect_rsp("R8 primary private", 64'h34010, 0, 0, 0);
        space_private = 3'b110;
        send(64'h10, 2'b01); expect_rsp("R8 primary shared", 64'h0, 1, 1, 0);
        space_sel = 2'b10; space_private = 3'b010;
        send(64'h10, 2'b01); expect_rsp("R8 secondary private", 64'h34010, 0, 0, 0);
        space_private = 3'b101;
        send(64'h10, 2'b01); expect_rsp("R8 secondary shared", 64'h0, 1, 1, 0);
        space_sel = 2'b11; space_private = 3'b100;
        send(64'h10, 2'b01); expect_rsp("R8 home private", 64'h34010, 0, 0, 0);
        space_private = 3'b011;
        send(64'h10, 2'b01); expect_rsp("R8 home shared", 64'h0, 1, 1, 0);
    endtask

    task automatic t_mode_err;
        prot_en = 1'b1; xlate_on = 1'b1; space_sel = 2'b01; space_private = 3'b000;
        send(64'h10, 2'b01);    expect_rsp("R10 access-register mode store", 64'h0, 0, 0, 1);
        prot_en = 1'b0;
        send(64'h36000, 2'b00); expect_rsp("R10 access-register mode load", 64'h0, 0, 0, 1);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefix_write();
        t_swap();
        t_guard_real();
        t_guard_spaces();
        t_mode_err();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule